// File: doc/BRIEF.md
# Delay Window Centering Unit

After a delay scan has found, for each byte lane, the lowest and highest delay taps at which data was captured correctly, this unit turns those two limits into the final delay tap for that lane. The limits arrive as signed values. A later extension search may push a limit below tap 0 or above the last tap, so the unit halves their sum and clamps the result into the legal tap range. In transmit mode it then adds the lane's write-leveling offset.

A one-cycle `start` pulse captures every lane's limits, the offsets and the mode. The unit then walks through the lanes in index order and presents one result per cycle, with `res_valid` and the lane index. After the last lane it pulses `done`. At that point two masks mark the lanes whose window is narrower than a threshold and pinned to tap 0 or to the top tap, so that the caller can run an extension search on those lanes. The masks are raised in receive mode only.

Top module: `window_center_unit`

## Requirements
- R1: The center of a lane is (high + low) / 2, with the division truncating toward zero. For example, limits 7 and 8 give 7, and limits 3 and 20 give 11.
- R2: A center below 0 is output as tap 0.
- R3: A center above 2**TAPW-1 (31 by default) is output as that top tap.
- R4: With `tx_mode`=1, `res_tap` is the clamped center plus the lane's unsigned offset. With `tx_mode`=0, `res_tap` is the clamped center and the offset has no effect.
- R5: In receive mode, bit i of `lo_ext_mask` is 1 exactly when lane i has (high − low) < THRESH and low = 0. A width equal to THRESH does not qualify.
- R6: In receive mode, bit i of `hi_ext_mask` is 1 exactly when lane i has (high − low) < THRESH and high = 2**TAPW-1.
- R7: In transmit mode, both masks are all zero when `done` is high.
- R8: When idle, a `start` pulse makes lane 0 appear in the next cycle with `res_valid`=1. The following lanes appear on consecutive cycles in index order, and `done` is high for exactly one cycle directly after the last lane.
- R9: Inputs are sampled only in the `start` cycle. A `start` pulse or an input change while lanes are being output has no effect on the results and does not restart the sequence.
- R10: After reset, `res_valid`, `done` and both masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that captures the inputs and begins a pass |
| tx_mode | input | 1 | 1 = transmit (add offset, no flags), 0 = receive |
| lo_lim | input | LANES*LW | Signed low limit per lane, lane i at [i*LW +: LW] |
| hi_lim | input | LANES*LW | Signed high limit per lane, same packing |
| lvl_off | input | LANES*OFFW | Unsigned leveling offset per lane, lane i at [i*OFFW +: OFFW] |
| res_valid | output | 1 | A lane result is present |
| res_lane | output | IDXW | Index of the lane being presented |
| res_tap | output | TAPW+1 | Final delay tap for that lane |
| done | output | 1 | One-cycle pulse after the last lane |
| lo_ext_mask | output | LANES | Lanes needing a low-side extension search |
| hi_ext_mask | output | LANES | Lanes needing a high-side extension search |

## Verification
The hardest situation to reach from the ports is a second `start` arriving in the middle of a pass, together with inputs that have changed meanwhile. The bench raises `start` and inverts the limit inputs right after lane 1 has been observed. It then checks that lanes 2 and 3 still carry the captured values and that no new pass begins after `done`. Flag edges are reached through limit pairs whose width is exactly THRESH and THRESH−1, and through a reversed pair whose width is negative. Clamping is reached through negative and out-of-range limits.

// File: rtl/wc_pkg.sv
package wc_pkg;
   typedef enum logic [1:0] {
      WC_IDLE = 2'd0,
      WC_RUN  = 2'd1,
      WC_FIN  = 2'd2
   } wc_state_e;
endpackage

// File: rtl/wc_center.sv
module wc_center #(
   parameter int LW   = 7,
   parameter int TAPW = 5,
   parameter int OFFW = 5
) (
   input  logic signed [LW-1:0] lo,
   input  logic signed [LW-1:0] hi,
   input  logic [OFFW-1:0]      off,
   input  logic                 add_off,
   output logic [TAPW:0]        tap
);
   localparam int TOP = (1 << TAPW) - 1;
   localparam logic signed [LW:0] TOP_S = (LW+1)'(TOP);

   logic signed [LW:0] sum_w;
   logic signed [LW:0] adj_w;
   logic signed [LW:0] half_w;
   logic [TAPW-1:0]    clamped;

   always_comb begin
      sum_w  = {lo[LW-1], lo} + {hi[LW-1], hi};
      // bias negative sums by one so the shift truncates toward zero
      adj_w  = sum_w + ((sum_w < 0) ? (LW+1)'(1) : (LW+1)'(0));
      half_w = adj_w >>> 1;
      if (half_w < 0)
         clamped = '0;
      else if (half_w > TOP_S)
         clamped = TAPW'(TOP);
      else
         clamped = half_w[TAPW-1:0];
      tap = add_off ? ({1'b0, clamped} + (TAPW+1)'(off)) : {1'b0, clamped};
   end
endmodule

// File: rtl/wc_edge_flag.sv
module wc_edge_flag #(
   parameter int LW     = 7,
   parameter int TAPW   = 5,
   parameter int THRESH = 8
) (
   input  logic signed [LW-1:0] lo,
   input  logic signed [LW-1:0] hi,
   input  logic                 rx_en,
   output logic                 lo_flag,
   output logic                 hi_flag
);
   localparam logic signed [LW-1:0] TOP_L = LW'((1 << TAPW) - 1);
   localparam logic signed [LW:0]   THR_S = (LW+1)'(THRESH);

   logic signed [LW:0] span;
   logic               narrow;

   always_comb begin
      span    = {hi[LW-1], hi} - {lo[LW-1], lo};
      narrow  = span < THR_S;
      lo_flag = rx_en && narrow && (lo == '0);
      hi_flag = rx_en && narrow && (hi == TOP_L);
   end
endmodule

// File: rtl/wc_seq.sv
module wc_seq
   import wc_pkg::*;
#(
   parameter int LANES = 4,
   localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   output logic            load,
   output logic            run,
   output logic            fin,
   output logic [IDXW-1:0] idx
);
   localparam logic [IDXW-1:0] LAST = IDXW'(LANES - 1);

   wc_state_e st;

   assign load = (st == WC_IDLE) && start;
   assign run  = (st == WC_RUN);
   assign fin  = (st == WC_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= WC_IDLE;
         idx <= '0;
      end else begin
         unique case (st)
            WC_IDLE: if (start) begin
               st  <= WC_RUN;
               idx <= '0;
            end
            WC_RUN: begin
               if (idx == LAST) st <= WC_FIN;
               else             idx <= idx + 1'b1;
            end
            WC_FIN:  st <= WC_IDLE;
            default: st <= WC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/window_center_unit.sv
module window_center_unit #(
   parameter int LANES  = 4,
   parameter int LW     = 7,
   parameter int TAPW   = 5,
   parameter int OFFW   = 5,
   parameter int THRESH = 8,
   localparam int IDXW  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  tx_mode,
   input  logic [LANES*LW-1:0]   lo_lim,
   input  logic [LANES*LW-1:0]   hi_lim,
   input  logic [LANES*OFFW-1:0] lvl_off,
   output logic                  res_valid,
   output logic [IDXW-1:0]       res_lane,
   output logic [TAPW:0]         res_tap,
   output logic                  done,
   output logic [LANES-1:0]      lo_ext_mask,
   output logic [LANES-1:0]      hi_ext_mask
);
   generate
      if (LANES < 1)       begin : g_bad_lanes  $error("LANES must be at least 1");          end
      if (LW < TAPW + 2)   begin : g_bad_lw     $error("LW must hold the top tap plus sign"); end
      if (OFFW > TAPW)     begin : g_bad_off    $error("OFFW must not exceed TAPW");          end
      if (THRESH < 1)      begin : g_bad_thr    $error("THRESH must be positive");            end
   endgenerate

   logic                  load, run, fin;
   logic [IDXW-1:0]       idx;
   logic                  tx_q;
   logic [LANES*LW-1:0]   lo_q, hi_q;
   logic [LANES*OFFW-1:0] off_q;

   logic signed [LW-1:0]  lo_lane [LANES];
   logic signed [LW-1:0]  hi_lane [LANES];
   logic [OFFW-1:0]       off_lane [LANES];

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_unpack
         assign lo_lane[gi]  = lo_q[gi*LW +: LW];
         assign hi_lane[gi]  = hi_q[gi*LW +: LW];
         assign off_lane[gi] = off_q[gi*OFFW +: OFFW];
      end
   endgenerate

   logic signed [LW-1:0] lo_sel, hi_sel;
   logic [OFFW-1:0]      off_sel;
   logic                 lo_f, hi_f;

   assign lo_sel  = lo_lane[idx];
   assign hi_sel  = hi_lane[idx];
   assign off_sel = off_lane[idx];

   wc_seq #(.LANES(LANES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .run(run), .fin(fin), .idx(idx)
   );

   wc_center #(.LW(LW), .TAPW(TAPW), .OFFW(OFFW)) u_ctr (
      .lo(lo_sel), .hi(hi_sel), .off(off_sel), .add_off(tx_q), .tap(res_tap)
   );

   wc_edge_flag #(.LW(LW), .TAPW(TAPW), .THRESH(THRESH)) u_flag (
      .lo(lo_sel), .hi(hi_sel), .rx_en(!tx_q), .lo_flag(lo_f), .hi_flag(hi_f)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= 1'b0;
         lo_q  <= '0;
         hi_q  <= '0;
         off_q <= '0;
      end else if (load) begin
         tx_q  <= tx_mode;
         lo_q  <= lo_lim;
         hi_q  <= hi_lim;
         off_q <= lvl_off;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_ext_mask <= '0;
         hi_ext_mask <= '0;
      end else if (load) begin
         lo_ext_mask <= '0;
         hi_ext_mask <= '0;
      end else if (run) begin
         lo_ext_mask[idx] <= lo_f;
         hi_ext_mask[idx] <= hi_f;
      end
   end

   assign res_valid = run;
   assign res_lane  = idx;
   assign done      = fin;
endmodule

// File: rtl/wc_chk.sv
module wc_chk #(
   parameter int LANES = 4,
   parameter int TAPW  = 5,
   localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            tx_q,
   input logic            res_valid,
   input logic [IDXW-1:0] res_lane,
   input logic [TAPW:0]   res_tap,
   input logic            done,
   input logic [LANES-1:0] lo_ext_mask,
   input logic [LANES-1:0] hi_ext_mask
);
   localparam logic [IDXW-1:0] LAST = IDXW'(LANES - 1);
   localparam logic [TAPW:0]   TOP  = (TAPW+1)'((1 << TAPW) - 1);

   a_r8_first_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !res_valid && !done) |=> (res_valid && res_lane == '0));

   a_r8_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_lane != LAST) |=> (res_valid && res_lane == IDXW'($past(res_lane) + 1'b1)));

   a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_lane == LAST) |=> (done && !res_valid));

   a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !res_valid));

   a_r7_tx_masks_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (done && tx_q) |-> (lo_ext_mask == '0 && hi_ext_mask == '0));

   a_r3_rx_tap_range: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !tx_q) |-> (res_tap <= TOP));
endmodule

bind window_center_unit wc_chk #(.LANES(LANES), .TAPW(TAPW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .tx_q(tx_q),
   .res_valid(res_valid), .res_lane(res_lane), .res_tap(res_tap), .done(done),
   .lo_ext_mask(lo_ext_mask), .hi_ext_mask(hi_ext_mask)
);

// File: tb/sim_window_center_unit.sv
`timescale 1ns/1ps
module sim_window_center_unit;
   localparam int LANES = 4, LW = 7, TAPW = 5, OFFW = 5, THRESH = 8;
   localparam int IDXW = 2;
   localparam int TOP = 31;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tx_mode = 1'b0;
   logic [LANES*LW-1:0]   lo_lim = '0, hi_lim = '0;
   logic [LANES*OFFW-1:0] lvl_off = '0;
   logic res_valid, done;
   logic [IDXW-1:0] res_lane;
   logic [TAPW:0]   res_tap;
   logic [LANES-1:0] lo_ext_mask, hi_ext_mask;

   int errors = 0, checks = 0;
   int lo_a[LANES], hi_a[LANES], off_a[LANES];

   always #5 clk = ~clk;

   window_center_unit #(.LANES(LANES), .LW(LW), .TAPW(TAPW), .OFFW(OFFW), .THRESH(THRESH)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_mode(tx_mode),
      .lo_lim(lo_lim), .hi_lim(hi_lim), .lvl_off(lvl_off),
      .res_valid(res_valid), .res_lane(res_lane), .res_tap(res_tap), .done(done),
      .lo_ext_mask(lo_ext_mask), .hi_ext_mask(hi_ext_mask)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int ref_tap(input int lo, input int hi, input int off, input bit tx);
      int c;
      c = (hi + lo) / 2;
      if (c < 0) c = 0;
      if (c > TOP) c = TOP;
      return tx ? c + off : c;
   endfunction

   task automatic set_lane(input int i, input int lo, input int hi, input int off);
      lo_a[i] = lo; hi_a[i] = hi; off_a[i] = off;
   endtask

   task automatic run_job(input string tag, input bit tx, input bit disturb);
      int exp_tap[LANES];
      int elo, ehi;
      elo = 0; ehi = 0;
      for (int i = 0; i < LANES; i++) begin
         exp_tap[i] = ref_tap(lo_a[i], hi_a[i], off_a[i], tx);
         if (!tx && (hi_a[i] - lo_a[i]) < THRESH && lo_a[i] == 0)   elo |= (1 << i);
         if (!tx && (hi_a[i] - lo_a[i]) < THRESH && hi_a[i] == TOP) ehi |= (1 << i);
      end
      @(negedge clk);
      for (int i = 0; i < LANES; i++) begin
         lo_lim[i*LW +: LW]    = LW'(lo_a[i]);
         hi_lim[i*LW +: LW]    = LW'(hi_a[i]);
         lvl_off[i*OFFW +: OFFW] = OFFW'(off_a[i]);
      end
      tx_mode = tx;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         if (i > 0) @(negedge clk);
         chk({tag, " R8 valid"}, int'(res_valid), 1);
         chk({tag, " R8 lane"}, int'(res_lane), i);
         chk({tag, " R1/R2/R3/R4 tap"}, int'(res_tap), exp_tap[i]);
         if (disturb && i == 1) begin
            start = 1'b1;            // R9: ignored mid-pass
            lo_lim = ~lo_lim;
            hi_lim = '0;
            tx_mode = ~tx_mode;
         end else begin
            start = 1'b0;
         end
      end
      @(negedge clk);
      start = 1'b0;
      chk({tag, " R8 done"}, int'(done), 1);
      chk({tag, " R8 valid low at done"}, int'(res_valid), 0);
      chk({tag, " R5/R7 lo mask"}, int'(lo_ext_mask), elo);
      chk({tag, " R6/R7 hi mask"}, int'(hi_ext_mask), ehi);
      @(negedge clk);
      chk({tag, " R9 no restart valid"}, int'(res_valid), 0);
      chk({tag, " R8 done one cycle"}, int'(done), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 valid after reset", int'(res_valid), 0);
      chk("R10 done after reset", int'(done), 0);
      chk("R10 masks after reset", int'({lo_ext_mask, hi_ext_mask}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 idle valid", int'(res_valid), 0);

      // receive, offsets present but ignored (R4), flags R5/R6
      set_lane(0, 3, 20, 4);  set_lane(1, 0, 5, 7);
      set_lane(2, 28, 31, 9); set_lane(3, 0, 31, 15);
      run_job("rx1", 1'b0, 1'b0);

      // transmit on the same limits: offset added, masks clear (R7)
      run_job("tx1", 1'b1, 1'b0);

      // clamping and negative limits (R1 R2 R3), reversed pair flags
      set_lane(0, -20, 5, 3); set_lane(1, 30, 40, 3);
      set_lane(2, 0, -2, 3);  set_lane(3, 7, 8, 3);
      run_job("rx2", 1'b0, 1'b0);

      // threshold boundary: width 7 flags, width 8 does not; disturbed mid-pass (R9)
      set_lane(0, 10, 12, 1); set_lane(1, 0, 7, 1);
      set_lane(2, 0, 8, 1);   set_lane(3, 24, 31, 1);
      run_job("rx3", 1'b0, 1'b1);

      // transmit with clamped-high center plus offset
      set_lane(0, 40, 50, 31); set_lane(1, -30, -10, 5);
      set_lane(2, 0, 3, 2);    set_lane(3, 26, 31, 0);
      run_job("tx2", 1'b1, 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule